// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event pulses from the logic around it into a register of sticky status bits. It also keeps a mask register, and it drives one interrupt request toward the host. The request pin is open-drain and active low. The block only ever enables a pull-down on it, and an external resistor pulls the line high when the block releases it.

Software reaches both registers through a small register port. The port has a write strobe, a one-bit address, write data and combinational read data. A status bit is cleared by writing 1 to its position.

After such a clear, some unmasked sources may still be pending. In that case the block releases the request line for exactly one clock and then pulls it low again. A host that detects interrupts on an edge then sees a new falling edge instead of a line that stays low.

The port is a plain control interface. It has no valid/ready handshake and applies no back-pressure. Every write is taken in the cycle its strobe is high, and reads never stall.

Top module: `irq_status_ctrl`

## Requirements
- R1: An event pulse on `evt_pulse[i]` sets status bit i on the next rising clock edge, and the bit stays set until software clears it.
- R2: Outside a release cycle (R5), `irq_od_en` is 1 exactly when some status bit i is 1 while mask bit i is 0. A mask bit of 1 blocks its source from the request.
- R3: A write to the status address clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: If an event on bit i arrives in the same clock as a write of 1 to status bit i, the event wins and the bit stays set.
- R5: A status write triggers a release cycle when all of the following hold:
  - before the write, two or more status bits were set;
  - the write hits at least one set bit;
  - after the write, at least one unmasked status bit is still set.

  In that case `irq_od_en` is 0 for exactly the one clock after the write, and is then 1 again if nothing else changed.
- R6: A write to the mask address replaces the mask register. The new mask governs `irq_od_en` from the next clock on.
- R7: After reset, both registers are zero and `irq_od_en` is 0. Reading either register has no side effect.
- R8: `reg_addr` = 0 selects the status register and `reg_addr` = 1 selects the mask register, for both reads and writes. `reg_rdata` shows the selected register combinationally.
- R9: `irq_od_en` = 1 means the pad pulls the active-low request line low. `irq_od_en` = 0 means the pad is released, so the block never drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 mask |
| reg_wdata | input | NUM_SRC | Write data (for status: 1 = clear) |
| reg_rdata | output | NUM_SRC | Read data of the selected register |
| irq_od_en | output | 1 | Pull-down enable for the active-low request pad |

## Verification
The embedded assertions check several rules on every cycle:
- an event always leaves its status bit set on the next clock;
- a set bit only falls when a 1 is written to it;
- the request is never enabled without an unmasked pending bit;
- a mask write governs the request on the following clock;
- a qualifying clear always releases the line on the next cycle.

Other behaviours are left to the bench's sweeps over a four-source configuration. These are the exact length of the release window and the line coming back afterwards, the full combination space of status, mask and clear patterns, event-versus-clear collisions, and reset values.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } isc_sel_e;

  localparam int unsigned DEF_NUM_SRC = 16;
endpackage

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] status_nxt_o
);
  logic [W-1:0] st_q;

  // per-bit set/clear, event dominates a simultaneous clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (evt_i[i])      status_nxt_o[i] = 1'b1;
      else if (clr_i[i]) status_nxt_o[i] = 1'b0;
      else               status_nxt_o[i] = st_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= status_nxt_o[i];
    end
  end

  assign status_o = st_q;

  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((st_q & $past(evt_i)) == $past(evt_i)));

  // R3
  hold_unless_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((st_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(wdata_i)));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/isc_irq_drive.sv
module isc_irq_drive #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] status_nxt_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic         od_en_o
);
  logic multi_set;
  logic hits_set;
  logic left_pending;
  logic blank_d;
  logic blank_q;

  // more than one bit set: clearing the lowest set bit leaves something
  assign multi_set    = (status_i & (status_i - W'(1))) != '0;
  assign hits_set     = (clr_i & status_i) != '0;
  assign left_pending = (status_nxt_i & ~mask_i) != '0;
  assign blank_d      = multi_set && hits_set && left_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blank_q <= 1'b0;
    else        blank_q <= blank_d;
  end

  assign od_en_o = ((status_i & ~mask_i) != '0) && !blank_q;

  // R5
  blank_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |=> !blank_q || $past(blank_d));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_od_en
);
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] status_nxt;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] clr;
  logic               wr_status;
  logic               wr_mask;

  assign wr_status = reg_wr && (isc_sel_e'(reg_addr) == SEL_STATUS);
  assign wr_mask   = reg_wr && (isc_sel_e'(reg_addr) == SEL_MASK);
  assign clr       = wr_status ? reg_wdata : '0;

  isc_status_reg #(.W(NUM_SRC)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt_pulse),
    .clr_i        (clr),
    .status_o     (status),
    .status_nxt_o (status_nxt)
  );

  isc_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_mask),
    .wdata_i (reg_wdata),
    .mask_o  (mask)
  );

  isc_irq_drive #(.W(NUM_SRC)) u_drive (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_i     (status),
    .status_nxt_i (status_nxt),
    .mask_i       (mask),
    .clr_i        (clr),
    .od_en_o      (irq_od_en)
  );

  always_comb begin
    case (isc_sel_e'(reg_addr))
      SEL_MASK: reg_rdata = mask;
      default:  reg_rdata = status;
    endcase
  end

  // R2
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_od_en |-> ((status & ~mask) != '0));

  // R6
  mask_next_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !wr_status) |=> (irq_od_en == ((status & ~mask) != '0)));

  // R5
  release_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && ($countones(status) > 1) && ((reg_wdata & status) != '0))
      |=> !irq_od_en);
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam int unsigned W = 4;
  localparam int unsigned N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_pulse = '0;
  logic         reg_wr = 1'b0;
  logic         reg_addr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq_od_en;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_status_ctrl #(.NUM_SRC(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_od_en (irq_od_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d, input logic [W-1:0] e);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evt_pulse = e;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [W-1:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic a, output logic [W-1:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  function automatic bit multi(input int v);
    return (v & (v - 1)) != 0;
  endfunction

  initial begin
    #300000;
    tests++; fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    // R7 reset state
    rd(1'b0, v); chk("R7 status reset", v, 0);
    rd(1'b1, v); chk("R7 mask reset", v, 0);
    chk("R7 irq reset", irq_od_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: status s, mask m, clear c
    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < N; m++) begin
        for (int c = 0; c < N; c++) begin
          int pend_after;
          bit blank;
          wr(1'b0, '1, '0);
          wr(1'b1, W'(m), '0);
          pulse(W'(s));
          // R1 / R8
          rd(1'b0, v); chk("R1 status set", v, s);
          rd(1'b1, v); chk("R8 mask read", v, m);
          // R9 / R2
          chk("R2 irq level", irq_od_en, ((s & ~m) & (N-1)) != 0);
          // R7 read has no side effect
          rd(1'b0, v); chk("R7 reread", v, s);
          wr(1'b0, W'(c), '0);
          pend_after = (s & ~c & ~m) & (N-1);
          blank = multi(s) && ((c & s) != 0) && (pend_after != 0);
          // R5 release cycle
          chk("R5 release", irq_od_en, (pend_after != 0) && !blank);
          // R3
          rd(1'b0, v); chk("R3 clear", v, s & ~c & (N-1));
          @(negedge clk);
          chk("R5 reassert", irq_od_en, pend_after != 0);
          if (c == 0) begin
            // R6 mask takes effect next clock
            wr(1'b1, '1, '0);
            chk("R6 mask all", irq_od_en, 0);
            wr(1'b1, W'(m), '0);
            chk("R6 mask restore", irq_od_en, pend_after != 0);
          end
        end
      end
    end

    // collisions: event with clear, mask open
    wr(1'b1, '0, '0);
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < N; c++) begin
        for (int e = 0; e < N; e += 5) begin
          int nxt;
          bit blank;
          wr(1'b0, '1, '0);
          pulse(W'(s));
          wr(1'b0, W'(c), W'(e));
          nxt = ((s & ~c) | e) & (N-1);
          blank = multi(s) && ((c & s) != 0) && (nxt != 0);
          rd(1'b0, v); chk("R4 event wins", v, nxt);
          chk("R4 irq", irq_od_en, (nxt != 0) && !blank);
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule